// File: doc/BRIEF.md
# Microstep Stepper Motor Indexer

This block converts a step clock into current commands for the two windings of a bipolar stepper motor. It keeps a position index within one electrical cycle of 32 eighth-step positions. Each rising edge of the step input moves the index forward or backward by a stride that depends on the selected excitation mode. The block outputs a polarity bit and a magnitude for each winding. The magnitude comes from one shared quarter-wave sine table and is then scaled by a four-level torque setting.

The step input is asynchronous. It is synchronized and edge-detected in the system clock domain. A downstream PWM current regulator uses the phase commands as its setpoints. Mode, direction, torque and enable are static configuration pins sampled on the system clock. The home flag tells the system controller when the motor sits at the reset position.

Top module: `stepper_indexer`

## Requirements
- R1: While `rst_n` is low and after its release, the index is 4 (45 degrees). At 100% torque both magnitudes then read 180, both polarity bits are 0 and `at_home` is 1.
- R2: Each rising edge of `step_in` moves the index modulo 32 within three clock cycles. The stride is set by `msel` = {M1,M2}: 00 full step (stride 8), 01 half step (stride 4), 10 quarter step (stride 2), 11 eighth step (stride 1).
- R3: `dir_rev` = 0 adds the stride to the index and `dir_rev` = 1 subtracts it.
- R4: At 100% torque, phase A magnitude equals round(255 x |sin(index x 11.25 deg)|). Phase A polarity is 1 exactly when the index lies in 16..31.
- R5: Phase B polarity and magnitude equal the phase A values for index (index + 8) mod 32, which is a 90-degree lead.
- R6: `tsel` = {TQ1,TQ2} scales both unscaled magnitudes m: 00 gives m, 10 gives floor(3m/4), 01 gives floor(m/2) and 11 gives floor(51m/256), which is about 20%.
- R7: With `en` low, both magnitudes and both polarity bits are 0 and `drv_en` is 0. With `en` high, `drv_en` is 1 and the outputs follow the index.
- R8: Step edges that occur while `en` is low do not move the index.
- R9: A change of `msel` snaps the index within two cycles, and that cycle takes no step. Full step gives (index AND 24) OR 4, half step gives index AND 28, quarter step gives index AND 30, and eighth step leaves the index unchanged.
- R10: `at_home` is 1 exactly when the index is 4.
- R11: A `step_in` level that is already high when reset is released does not cause a step. Its later fall does not cause a step either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset to the home position |
| step_in | input | 1 | Asynchronous step clock, acts on its rising edge |
| dir_rev | input | 1 | 0 forward, 1 reverse |
| msel | input | 2 | Excitation mode {M1,M2} |
| tsel | input | 2 | Torque level {TQ1,TQ2} |
| en | input | 1 | Output enable, active high |
| pha_pol | output | 1 | Phase A polarity, 1 means negative current |
| pha_mag | output | 8 | Phase A current magnitude |
| phb_pol | output | 1 | Phase B polarity, 1 means negative current |
| phb_mag | output | 8 | Phase B current magnitude |
| drv_en | output | 1 | Bridge enable |
| at_home | output | 1 | Index is at the home position |

## Verification
The assertions assume that `msel`, `tsel`, `dir_rev` and `en` are synchronous to `clk`. They also assume that every `step_in` level lasts several clock cycles, so the synchronizer sees each edge exactly once. The bench changes every input on the falling clock edge. It holds each step level for four cycles and waits two cycles after a mode change before it steps again. This keeps every snap separate from every stride. The expected values come from a software index model and the real sine function.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;

   localparam int IDX_W = 5;
   localparam int MAG_W = 8;
   localparam logic [IDX_W-1:0] HOME_IDX = 5'd4;

   typedef enum logic [1:0] {
      MODE_FULL   = 2'b00,
      MODE_HALF   = 2'b01,
      MODE_QUART  = 2'b10,
      MODE_EIGHTH = 2'b11
   } step_mode_e;

   typedef enum logic [1:0] {
      TQ_100 = 2'b00,
      TQ_50  = 2'b01,
      TQ_75  = 2'b10,
      TQ_20  = 2'b11
   } torque_e;

   function automatic logic [IDX_W-1:0] stride_of(step_mode_e m);
      case (m)
         MODE_FULL:  return 5'd8;
         MODE_HALF:  return 5'd4;
         MODE_QUART: return 5'd2;
         default:    return 5'd1;
      endcase
   endfunction

   function automatic logic [IDX_W-1:0] snap_to(logic [IDX_W-1:0] idx, step_mode_e m);
      case (m)
         MODE_FULL:  return (idx & 5'b11000) | 5'b00100;
         MODE_HALF:  return idx & 5'b11100;
         MODE_QUART: return idx & 5'b11110;
         default:    return idx;
      endcase
   endfunction

   // quarter-wave sine, 9 points from 0 to 90 degrees, full scale 255
   function automatic logic [MAG_W-1:0] sine_q(logic [3:0] k);
      case (k)
         4'd0:    return 8'd0;
         4'd1:    return 8'd50;
         4'd2:    return 8'd98;
         4'd3:    return 8'd142;
         4'd4:    return 8'd180;
         4'd5:    return 8'd212;
         4'd6:    return 8'd236;
         4'd7:    return 8'd250;
         4'd8:    return 8'd255;
         default: return 8'd0;
      endcase
   endfunction

endpackage

// File: rtl/step_sync.sv
module step_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("step_sync: STAGES must be at least 2");
      end
   endgenerate

   // chain preset to ones: a level held high through reset yields no edge
   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], din};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/step_counter.sv
module step_counter
   import stepidx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             dir_rev,
   input  logic             en,
   input  logic [1:0]       msel,
   output logic [IDX_W-1:0] idx
);
   step_mode_e       mode_q;
   step_mode_e       mode_in;
   logic             mode_chg;
   logic [IDX_W-1:0] stride;

   assign mode_in  = step_mode_e'(msel);
   assign mode_chg = (mode_in != mode_q);
   assign stride   = stride_of(mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= HOME_IDX;
         mode_q <= MODE_FULL;
      end else if (mode_chg) begin
         mode_q <= mode_in;
         idx    <= snap_to(idx, mode_in);
      end else if (adv && en) begin
         idx <= dir_rev ? idx - stride : idx + stride;
      end
   end

   AST_FULL_LATTICE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_FULL) |-> (idx[2:0] == 3'd4)); // R9

   AST_HALF_LATTICE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_HALF) |-> (idx[1:0] == 2'd0)); // R9

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !mode_chg) |=> $stable(idx)); // R8

endmodule

// File: rtl/phase_lookup.sv
module phase_lookup
   import stepidx_pkg::*;
#(
   parameter int OFFSET = 0
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [1:0]       tsel,
   input  logic             en,
   output logic             pol,
   output logic [MAG_W-1:0] mag
);
   localparam logic [IDX_W-1:0] OFF_V = IDX_W'(OFFSET);

   logic [IDX_W-1:0] pos;
   logic [3:0]       fold;
   logic [MAG_W-1:0] raw;
   logic [15:0]      prod;
   logic [MAG_W-1:0] scaled;

   assign pos  = idx + OFF_V;
   assign fold = pos[3] ? (4'd8 - {1'b0, pos[2:0]}) : {1'b0, pos[2:0]};
   assign raw  = sine_q(fold);

   always_comb begin
      prod = 16'd0;
      case (torque_e'(tsel))
         TQ_100: prod = {8'd0, raw};
         TQ_75:  prod = ({8'd0, raw} * 16'd3) >> 2;
         TQ_50:  prod = {8'd0, raw} >> 1;
         default: prod = ({8'd0, raw} * 16'd51) >> 8;
      endcase
      scaled = prod[MAG_W-1:0];
   end

   assign mag = en ? scaled : '0;
   assign pol = en & pos[IDX_W-1];

endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
   import stepidx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PHASES      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_in,
   input  logic             dir_rev,
   input  logic [1:0]       msel,
   input  logic [1:0]       tsel,
   input  logic             en,
   output logic             pha_pol,
   output logic [MAG_W-1:0] pha_mag,
   output logic             phb_pol,
   output logic [MAG_W-1:0] phb_mag,
   output logic             drv_en,
   output logic             at_home
);
   localparam int QUARTER = 2 ** (IDX_W - 2);

   generate
      if (PHASES != 2) begin : g_bad_phases
         $error("stepper_indexer: only two phases are supported");
      end
   endgenerate

   logic             adv;
   logic [IDX_W-1:0] idx;
   logic             pol_w [PHASES];
   logic [MAG_W-1:0] mag_w [PHASES];

   step_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (step_in),
      .rise (adv)
   );

   step_counter u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .dir_rev(dir_rev),
      .en     (en),
      .msel   (msel),
      .idx    (idx)
   );

   genvar g;
   generate
      for (g = 0; g < PHASES; g++) begin : g_phase
         phase_lookup #(.OFFSET(g * QUARTER)) u_lk (
            .idx (idx),
            .tsel(tsel),
            .en  (en),
            .pol (pol_w[g]),
            .mag (mag_w[g])
         );
      end
   endgenerate

   assign pha_pol = pol_w[0];
   assign pha_mag = mag_w[0];
   assign phb_pol = pol_w[1];
   assign phb_mag = mag_w[1];
   assign drv_en  = en;
   assign at_home = (idx == HOME_IDX);

   AST_HOME_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (at_home && drv_en) |-> (pha_mag == phb_mag && !pha_pol && !phb_pol)); // R10

   AST_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (pha_mag == '0 && phb_mag == '0 && !pha_pol && !phb_pol && !drv_en)); // R7

   AST_QUADRATURE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tsel == 2'b00) |-> (pha_mag >= 8'd180 || phb_mag >= 8'd180)); // R5

endmodule

// File: tb/stepper_indexer_test.sv
module stepper_indexer_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_in = 1'b0;
   logic       dir_rev = 1'b0;
   logic [1:0] msel = 2'b11;
   logic [1:0] tsel = 2'b00;
   logic       en = 1'b1;
   logic       pha_pol, phb_pol, drv_en, at_home;
   logic [7:0] pha_mag, phb_mag;

   int total = 0;
   int bad = 0;
   int m_idx = 4;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stepper_indexer uut (
      .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_rev(dir_rev),
      .msel(msel), .tsel(tsel), .en(en),
      .pha_pol(pha_pol), .pha_mag(pha_mag), .phb_pol(phb_pol),
      .phb_mag(phb_mag), .drv_en(drv_en), .at_home(at_home)
   );

   function automatic int raw_mag(int k);
      real r;
      r = 255.0 * $sin(3.14159265358979 * real'(k) / 16.0);
      if (r < 0.0) r = -r;
      return $rtoi(r + 0.5);
   endfunction

   function automatic int scale(int m, logic [1:0] t);
      case (t)
         2'b00: return m;
         2'b10: return (3 * m) / 4;
         2'b01: return m / 2;
         default: return (51 * m) / 256;
      endcase
   endfunction

   function automatic int stride(logic [1:0] m);
      case (m)
         2'b00: return 8;
         2'b01: return 4;
         2'b10: return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int snap(int i, logic [1:0] m);
      case (m)
         2'b00: return (i & 24) | 4;
         2'b01: return i & 28;
         2'b10: return i & 30;
         default: return i;
      endcase
   endfunction

   task automatic check_all(string req);
      int ka, kb, ea, eb, epa, epb, eh, ed;
      ka = m_idx;
      kb = (m_idx + 8) % 32;
      ed = en ? 1 : 0;
      ea = en ? scale(raw_mag(ka), tsel) : 0;
      eb = en ? scale(raw_mag(kb), tsel) : 0;
      epa = (en && ka >= 16) ? 1 : 0;
      epb = (en && kb >= 16) ? 1 : 0;
      eh = (m_idx == 4) ? 1 : 0;
      total++;
      if (int'(pha_mag) != ea || int'(phb_mag) != eb || int'(pha_pol) != epa ||
          int'(phb_pol) != epb || int'(drv_en) != ed || int'(at_home) != eh) begin
         bad++;
         $display("FAIL %s idx=%0d actual a=%0d/%0d b=%0d/%0d en=%0d home=%0d expected a=%0d/%0d b=%0d/%0d en=%0d home=%0d",
                  req, m_idx, pha_pol, pha_mag, phb_pol, phb_mag, drv_en, at_home,
                  epa, ea, epb, eb, ed, eh);
      end
   endtask

   task automatic pulse();
      @(negedge clk) step_in = 1'b1;
      repeat (4) @(negedge clk);
      step_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic step_model();
      pulse();
      if (en) m_idx = (m_idx + 32 + (dir_rev ? -stride(msel) : stride(msel))) % 32;
   endtask

   task automatic set_mode(logic [1:0] m);
      @(negedge clk) msel = m;
      repeat (2) @(negedge clk);
      m_idx = snap(m_idx, m);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 home after reset");

      // R2 R4 R5 R10: eighth-step forward sweep over the full cycle
      dir_rev = 1'b0;
      for (int i = 0; i < 32; i++) begin
         step_model();
         check_all("R2 R4 R5 R10 eighth fwd");
      end

      // R3 R6: reverse sweep while cycling torque levels
      dir_rev = 1'b1;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk) tsel = 2'(i % 4);
         step_model();
         check_all("R3 R6 reverse with torque");
      end
      tsel = 2'b00;

      // R9 R2: every mode, snap then strides in both directions
      for (int m = 0; m < 4; m++) begin
         step_model();
         set_mode(2'(m));
         check_all("R9 snap on mode change");
         for (int i = 0; i < 10; i++) begin
            dir_rev = (i >= 6);
            step_model();
            check_all("R2 R3 mode strides");
         end
      end

      // R7 R8: disabled outputs and ignored edges
      set_mode(2'b11);
      @(negedge clk) en = 1'b0;
      @(negedge clk);
      check_all("R7 outputs off");
      dir_rev = 1'b0;
      step_model();
      step_model();
      check_all("R7 R8 still off");
      @(negedge clk) en = 1'b1;
      @(negedge clk);
      check_all("R8 index unchanged after enable");

      // R11: step held high across reset release
      @(negedge clk) rst_n = 1'b0;
      step_in = 1'b1;
      m_idx = 4;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_all("R11 no step from held level");
      step_in = 1'b0;
      repeat (5) @(negedge clk);
      check_all("R11 no step on fall");
      step_model();
      check_all("R2 step after reset");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1-timeout actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule